// File: doc/BRIEF.md
# SMM entry and soft-reset controller

This block is the processor-side control for system management mode and soft reset. It watches two asynchronous requests, a management interrupt and a soft reset. Each is synchronised, reduced to its rising edge and kept as a sticky pending flag until the core reports an instruction boundary. At a boundary the block either enters management mode or starts a soft-reset sequence. On entry it lowers an active-low mode flag and pulses a request to save internal state.

The mode flag is a plain register output with no enable or float path. Only the resume-complete strobe or a hard reset clears it. The block also holds a small register that stands in for state that soft reset must preserve: the cache-disable and no-write-through bits, an FPU state byte and the management base address. It also keeps a write-back mode bit that is taken from a strap input only while hard reset is asserted. A soft reset never reloads any of these.

Hard reset is synchronous and active high. It clears both pending flags and the mode, and it restores the preserved register to its defaults. Instruction execution, the save writes themselves and the cache are handled elsewhere.

Top module: `smm_sreset_ctrl`

## Requirements
- R1: A rising edge on `smi_req_i` becomes pending on the third rising clock edge after it is sampled. At the first clock edge after that where `insn_bnd_i` is high and the block is not in management mode, the block enters the mode and `smm_act_n_o` goes low on that same edge.
- R2: `save_req_o` is high for exactly one cycle. That cycle is the one in which `smm_act_n_o` first reads low, and `save_req_o` is high on no other cycle.
- R3: Once low, `smm_act_n_o` stays low until a clock edge that samples `rsm_done_i` high, or until hard reset. Soft-reset sequences and further boundaries do not raise it.
- R4: `smm_act_n_o` is a registered output with a known value on every cycle after reset. No input other than `rsm_done_i` and `hard_rst_i` can force it high.
- R5: A rising edge on `soft_rst_i` becomes pending after the same three-edge latency as R1. `soft_rst_seq_o` then pulses high for one cycle on the next boundary that does not take a management interrupt.
- R6: A soft-reset sequence leaves `cfg_o` and `wb_mode_o` unchanged. This holds even when `wb_strap_i` has changed since hard reset.
- R7: While `hard_rst_i` is high, the block drives `smm_act_n_o` to 1, clears both pending requests and loads `cfg_o` with defaults: bit 0 (cache disable) = 1, bit 1 (no write-through) = 1, FPU byte = 0, base = `BASE_DEFAULT`. It also copies `wb_strap_i` into `wb_mode_o`.
- R8: If both requests are pending at one boundary, the management interrupt is taken and the soft reset stays pending until the next boundary.
- R9: A management interrupt that arrives while in the mode stays pending. It is taken at the first boundary after resume.
- R10: Without a boundary strobe, pending requests wait for any number of cycles and no output changes.
- R11: A soft-reset edge while the mode is active is an environment error. The system must block it, and the bound checker reports it.
- R12: A clock edge with `cfg_we_i` high loads `cfg_wdata_i` into `cfg_o`. The layout is bit 0 cache disable, bit 1 no write-through, bits [9:2] FPU state and bits [41:10] base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| hard_rst_i | input | 1 | Synchronous hard reset, active high |
| wb_strap_i | input | 1 | Write-back mode strap, captured during hard reset |
| smi_req_i | input | 1 | Latched management interrupt request, asynchronous |
| soft_rst_i | input | 1 | Soft reset request, asynchronous, active high |
| insn_bnd_i | input | 1 | Instruction boundary strobe |
| rsm_done_i | input | 1 | Resume instruction completed |
| cfg_we_i | input | 1 | Write enable for the preserved register |
| cfg_wdata_i | input | 42 | Write data for the preserved register |
| smm_act_n_o | output | 1 | Management mode active, active low |
| save_req_o | output | 1 | One-cycle request to save internal state |
| soft_rst_seq_o | output | 1 | One-cycle start of the soft-reset sequence |
| cfg_o | output | 42 | Preserved register contents |
| wb_mode_o | output | 1 | Write-back mode captured at hard reset |

## Verification
The boundary logic is driven with each request alone and with both requests raised together. This separates the plain entry and soft-reset paths from the priority rule. A management interrupt is raised inside the mode and then followed by a resume. This shows whether a blocked request is held or dropped. Long gaps without a boundary, a hard reset over pending requests, and random sequences of requests, boundaries, resumes and register writes check that the pending flags, the mode and the preserved register evolve as a model built from the requirements predicts.

// File: rtl/smm_ctrl_pkg.sv
`timescale 1ns/1ps
package smm_ctrl_pkg;
    localparam int FPU_W  = 8;
    localparam int BASE_W = 32;
    localparam logic [BASE_W-1:0] BASE_RST = 32'h0003_0000;

    // request source indices
    localparam int NSRC     = 2;
    localparam int IDX_SMI  = 0;
    localparam int IDX_SRST = 1;

    // preserved state, bit 0 = cache disable, bit 1 = no write-through
    typedef struct packed {
        logic [BASE_W-1:0] base;
        logic [FPU_W-1:0]  fpu;
        logic              nowt;
        logic              cdis;
    } keep_cfg_t;

    localparam int CFG_W = $bits(keep_cfg_t);

    typedef struct packed {
        logic mode;
        logic save;
        logic srst;
    } core_t;
endpackage

// File: rtl/smm_edge_sync.sv
`timescale 1ns/1ps
module smm_edge_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk_i,
    input  logic         rst_i,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] rise_o
);
    // STAGES synchroniser flops plus one history flop for edge detection
    logic [STAGES:0][W-1:0] pipe_d, pipe_q;

    always_comb begin
        pipe_d    = pipe_q;
        pipe_d[0] = async_i;
        for (int k = 1; k <= STAGES; k++) begin
            pipe_d[k] = pipe_q[k-1];
        end
        if (rst_i) begin
            pipe_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        pipe_q <= pipe_d;
    end

    assign rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
endmodule

// File: rtl/smm_boundary_arb.sv
`timescale 1ns/1ps
module smm_boundary_arb
    import smm_ctrl_pkg::*;
(
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NSRC-1:0] rise_i,
    input  logic            bnd_i,
    input  logic            in_mode_i,
    output logic            take_smi_o,
    output logic            take_srst_o
);
    logic [NSRC-1:0] pend_d, pend_q;
    logic            take_smi, take_srst;

    always_comb begin
        // interrupt wins a shared boundary; it is held while already in the mode
        take_smi  = bnd_i & pend_q[IDX_SMI] & ~in_mode_i;
        take_srst = bnd_i & pend_q[IDX_SRST] & ~take_smi;

        pend_d           = pend_q;
        pend_d[IDX_SMI]  = (pend_q[IDX_SMI]  & ~take_smi)  | rise_i[IDX_SMI];
        pend_d[IDX_SRST] = (pend_q[IDX_SRST] & ~take_srst) | rise_i[IDX_SRST];

        if (rst_i) begin
            pend_d    = '0;
            take_smi  = 1'b0;
            take_srst = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        pend_q <= pend_d;
    end

    assign take_smi_o  = take_smi;
    assign take_srst_o = take_srst;
endmodule

// File: rtl/smm_keep_cfg.sv
`timescale 1ns/1ps
module smm_keep_cfg
    import smm_ctrl_pkg::*;
#(
    parameter logic [BASE_W-1:0] BASE_DEFAULT = BASE_RST
) (
    input  logic      clk_i,
    input  logic      rst_i,
    input  logic      strap_i,
    input  logic      we_i,
    input  keep_cfg_t wdata_i,
    output keep_cfg_t cfg_o,
    output logic      wb_mode_o
);
    typedef struct packed {
        keep_cfg_t cfg;
        logic      wb;
    } keep_t;

    keep_t keep_d, keep_q;

    // no soft-reset input reaches this register at all
    always_comb begin
        keep_d = keep_q;
        if (we_i) begin
            keep_d.cfg = wdata_i;
        end
        if (rst_i) begin
            keep_d.cfg.base = BASE_DEFAULT;
            keep_d.cfg.fpu  = '0;
            keep_d.cfg.nowt = 1'b1;
            keep_d.cfg.cdis = 1'b1;
            keep_d.wb       = strap_i;
        end
    end

    always_ff @(posedge clk_i) begin
        keep_q <= keep_d;
    end

    assign cfg_o     = keep_q.cfg;
    assign wb_mode_o = keep_q.wb;
endmodule

// File: rtl/smm_sreset_ctrl.sv
`timescale 1ns/1ps
module smm_sreset_ctrl
    import smm_ctrl_pkg::*;
#(
    parameter int                SYNC_STAGES  = 2,
    parameter logic [BASE_W-1:0] BASE_DEFAULT = BASE_RST
) (
    input  logic             clk_i,
    input  logic             hard_rst_i,
    input  logic             wb_strap_i,
    input  logic             smi_req_i,
    input  logic             soft_rst_i,
    input  logic             insn_bnd_i,
    input  logic             rsm_done_i,
    input  logic             cfg_we_i,
    input  logic [CFG_W-1:0] cfg_wdata_i,
    output logic             smm_act_n_o,
    output logic             save_req_o,
    output logic             soft_rst_seq_o,
    output logic [CFG_W-1:0] cfg_o,
    output logic             wb_mode_o
);
    logic [NSRC-1:0] async_req;
    logic [NSRC-1:0] req_rise;
    logic            srst_edge;
    logic            take_smi, take_srst;
    keep_cfg_t       cfg_wr, cfg_rd;
    core_t           core_d, core_q;

    assign async_req[IDX_SMI]  = smi_req_i;
    assign async_req[IDX_SRST] = soft_rst_i;
    assign srst_edge           = req_rise[IDX_SRST];

    smm_edge_sync #(
        .W      (NSRC),
        .STAGES (SYNC_STAGES)
    ) sync_i (
        .clk_i   (clk_i),
        .rst_i   (hard_rst_i),
        .async_i (async_req),
        .rise_o  (req_rise)
    );

    smm_boundary_arb arb_i (
        .clk_i       (clk_i),
        .rst_i       (hard_rst_i),
        .rise_i      (req_rise),
        .bnd_i       (insn_bnd_i),
        .in_mode_i   (core_q.mode),
        .take_smi_o  (take_smi),
        .take_srst_o (take_srst)
    );

    assign cfg_wr = keep_cfg_t'(cfg_wdata_i);

    smm_keep_cfg #(
        .BASE_DEFAULT (BASE_DEFAULT)
    ) keep_i (
        .clk_i     (clk_i),
        .rst_i     (hard_rst_i),
        .strap_i   (wb_strap_i),
        .we_i      (cfg_we_i),
        .wdata_i   (cfg_wr),
        .cfg_o     (cfg_rd),
        .wb_mode_o (wb_mode_o)
    );

    always_comb begin
        core_d      = core_q;
        core_d.save = take_smi;
        core_d.srst = take_srst;
        if (take_smi) begin
            core_d.mode = 1'b1;
        end else if (rsm_done_i) begin
            core_d.mode = 1'b0;
        end
        if (hard_rst_i) begin
            core_d = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        core_q <= core_d;
    end

    assign smm_act_n_o    = ~core_q.mode;
    assign save_req_o     = core_q.save;
    assign soft_rst_seq_o = core_q.srst;
    assign cfg_o          = cfg_rd;
endmodule

// File: rtl/smm_sreset_ctrl_chk.sv
`timescale 1ns/1ps
module smm_sreset_ctrl_chk (
    input logic clk_i,
    input logic hard_rst_i,
    input logic smm_act_n_i,
    input logic save_req_i,
    input logic srst_seq_i,
    input logic rsm_done_i,
    input logic srst_edge_i
);
    // R1: every entry into the mode comes with a save request
    a_r1_entry_saves: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        $fell(smm_act_n_i) |-> save_req_i);

    // R2: a save request only marks the entry cycle
    a_r2_save_on_entry: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        save_req_i |-> $fell(smm_act_n_i));

    // R3: the mode holds unless resume is seen
    a_r3_mode_holds: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        (!smm_act_n_i && !rsm_done_i) |=> !smm_act_n_i);

    // R3: leaving the mode needs a resume on the previous edge
    a_r3_exit_by_resume: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        $rose(smm_act_n_i) |-> $past(rsm_done_i));

    // R4: the mode flag is always driven to a known level
    a_r4_driven: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        !$isunknown(smm_act_n_i));

    // R8: one service per boundary
    a_r8_single_service: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        !(save_req_i && srst_seq_i));

    // R11: soft reset must be blocked while in the mode
    a_r11_no_srst_in_mode: assert property (@(posedge clk_i) disable iff (hard_rst_i)
        srst_edge_i |-> smm_act_n_i);
endmodule

bind smm_sreset_ctrl smm_sreset_ctrl_chk chk_i (
    .clk_i       (clk_i),
    .hard_rst_i  (hard_rst_i),
    .smm_act_n_i (smm_act_n_o),
    .save_req_i  (save_req_o),
    .srst_seq_i  (soft_rst_seq_o),
    .rsm_done_i  (rsm_done_i),
    .srst_edge_i (srst_edge)
);

// File: tb/smm_sreset_ctrl_tb_top.sv
`timescale 1ns/1ps
module smm_sreset_ctrl_tb_top;
    localparam int          TB_CFG_W = 42;
    localparam logic [31:0] TB_BASE  = 32'h0003_0000;

    logic                clk = 1'b0;
    logic                hard_rst = 1'b1;
    logic                wb_strap = 1'b0;
    logic                smi_req = 1'b0;
    logic                soft_rst = 1'b0;
    logic                insn_bnd = 1'b0;
    logic                rsm_done = 1'b0;
    logic                cfg_we = 1'b0;
    logic [TB_CFG_W-1:0] cfg_wdata = '0;
    logic                smm_act_n;
    logic                save_req;
    logic                soft_rst_seq;
    logic [TB_CFG_W-1:0] cfg_out;
    logic                wb_mode;

    int checks = 0;
    int errors = 0;

    // model state derived from the requirements
    bit                  m_smm;
    bit                  m_psmi;
    bit                  m_psrst;
    logic [TB_CFG_W-1:0] m_cfg;
    bit                  m_wb;

    always #4 clk = ~clk;

    smm_sreset_ctrl dut_i (
        .clk_i          (clk),
        .hard_rst_i     (hard_rst),
        .wb_strap_i     (wb_strap),
        .smi_req_i      (smi_req),
        .soft_rst_i     (soft_rst),
        .insn_bnd_i     (insn_bnd),
        .rsm_done_i     (rsm_done),
        .cfg_we_i       (cfg_we),
        .cfg_wdata_i    (cfg_wdata),
        .smm_act_n_o    (smm_act_n),
        .save_req_o     (save_req),
        .soft_rst_seq_o (soft_rst_seq),
        .cfg_o          (cfg_out),
        .wb_mode_o      (wb_mode)
    );

    function automatic logic [TB_CFG_W-1:0] default_cfg();
        return {TB_BASE, 8'h00, 1'b1, 1'b1};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit strap);
        hard_rst = 1'b1;
        wb_strap = strap;
        smi_req = 1'b0; soft_rst = 1'b0; insn_bnd = 1'b0; rsm_done = 1'b0; cfg_we = 1'b0;
        repeat (3) tick();
        hard_rst = 1'b0;
        m_smm = 0; m_psmi = 0; m_psrst = 0; m_cfg = default_cfg(); m_wb = strap;
        chk("R7 mode flag", 64'(smm_act_n), 64'd1);
        chk("R7 save idle", 64'(save_req), 64'd0);
        chk("R7 srst idle", 64'(soft_rst_seq), 64'd0);
        chk("R7 cfg default", 64'(cfg_out), 64'(m_cfg));
        chk("R7 wb strap", 64'(wb_mode), 64'(m_wb));
    endtask

    task automatic raise(input bit do_smi, input bit do_srst);
        smi_req = do_smi;
        soft_rst = do_srst;
        repeat (3) tick();
        smi_req = 1'b0;
        soft_rst = 1'b0;
        repeat (3) tick();
        if (do_smi)  m_psmi = 1;
        if (do_srst) m_psrst = 1;
    endtask

    task automatic boundary();
        bit e_save;
        bit e_srst;
        e_save = m_psmi && !m_smm;
        e_srst = m_psrst && !e_save;
        if (e_save) begin m_psmi = 0; m_smm = 1; end
        if (e_srst) m_psrst = 0;
        insn_bnd = 1'b1;
        tick();
        insn_bnd = 1'b0;
        chk("R1 R2 save pulse", 64'(save_req), 64'(e_save));
        chk("R5 R8 srst pulse", 64'(soft_rst_seq), 64'(e_srst));
        chk("R3 mode flag", 64'(smm_act_n), 64'(!m_smm));
        chk("R6 cfg kept", 64'(cfg_out), 64'(m_cfg));
        chk("R6 wb kept", 64'(wb_mode), 64'(m_wb));
        tick();
        chk("R2 save one cycle", 64'(save_req), 64'd0);
        chk("R5 srst one cycle", 64'(soft_rst_seq), 64'd0);
    endtask

    task automatic resume();
        rsm_done = 1'b1;
        tick();
        rsm_done = 1'b0;
        m_smm = 0;
        chk("R3 exit on resume", 64'(smm_act_n), 64'd1);
    endtask

    task automatic write_cfg(input logic [TB_CFG_W-1:0] v);
        cfg_we = 1'b1;
        cfg_wdata = v;
        tick();
        cfg_we = 1'b0;
        m_cfg = v;
        chk("R12 cfg write", 64'(cfg_out), 64'(m_cfg));
    endtask

    initial begin
        logic [63:0] rnd;
        void'($urandom(32'd2024));
        do_reset(1'b1);

        // R10: pending waits without a boundary
        raise(1'b1, 1'b0);
        repeat (10) tick();
        chk("R10 no change mode", 64'(smm_act_n), 64'd1);
        chk("R10 no change save", 64'(save_req), 64'd0);
        boundary();

        // R3: mode holds across idle cycles
        repeat (5) tick();
        chk("R3 mode held", 64'(smm_act_n), 64'd0);
        resume();

        // R6: soft reset after strap change keeps preserved state
        write_cfg(42'h2AB_CDEF_0123);
        wb_strap = 1'b0;
        raise(1'b0, 1'b1);
        boundary();

        // R8: both pending, interrupt first, then soft reset
        raise(1'b1, 1'b1);
        boundary();
        boundary();
        chk("R3 R8 mode after srst", 64'(smm_act_n), 64'd0);
        resume();

        // R9: interrupt inside the mode is held until resume
        raise(1'b1, 1'b0);
        boundary();
        raise(1'b1, 1'b0);
        boundary();
        resume();
        boundary();
        resume();

        // R7: hard reset in the mode drops pending requests
        raise(1'b1, 1'b0);
        boundary();
        raise(1'b1, 1'b0);
        do_reset(1'b0);
        boundary();

        // random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            op = int'($urandom_range(0, 4));
            case (op)
                0: raise(1'b1, 1'b0);
                1: if (!m_smm) raise(1'b0, 1'b1); else boundary();
                2: boundary();
                3: if (m_smm) resume(); else boundary();
                default: begin
                    rnd = {$urandom, $urandom};
                    write_cfg(rnd[TB_CFG_W-1:0]);
                end
            endcase
            repeat ($urandom_range(0, 3)) tick();
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule